// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Overflow

This block is a purely combinational two's-complement adder/subtractor. Its width is a parameter, and the default is 4 bits. One carry chain serves both operations. A mode input selects addition or subtraction.

For subtraction, every bit of the second operand is flipped and a 1 is fed into the lowest carry. The chain then adds the first operand to the negated second operand.

The unit gives three outputs:
- the truncated result;
- the raw carry out of the top bit, which is meaningful for unsigned operands;
- a signed overflow flag, formed by comparing the carry that enters the top bit with the carry that leaves it.

A datapath uses the result as a signed value only when the overflow flag is low.

Top module: `addsub_unit`

## Requirements
- R1: With sub_i = 0, sum_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With sub_i = 1, sum_o equals (a_i - b_i) modulo 2^WIDTH. This is formed as a_i + ~b_i + 1.
- R3: carry_o is the carry out of the most significant bit. With sub_i = 0 it is 1 exactly when the unsigned sum a_i + b_i exceeds 2^WIDTH - 1. With sub_i = 1 it is 1 exactly when a_i >= b_i as unsigned values.
- R4: ovf_o is 1 exactly when the true signed result, with both operands read as two's complement, lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1) - 1.
- R5: With sub_i = 0, operands whose sign bits differ never raise ovf_o.
- R6: At 4 bits, 7 + 3 gives sum_o = 4'b1010 with ovf_o = 1 and carry_o = 0.
- R7: At 4 bits, -4 - 5 (a_i = 4'b1100, b_i = 4'b0101, sub_i = 1) gives sum_o = 4'b0111 with ovf_o = 1 and carry_o = 1.
- R8: At 4 bits, 5 + (-6) gives 4'b1111 with ovf_o = 0 and carry_o = 0. Also at 4 bits, 7 + (-3) gives 4'b0100 with carry_o = 1 and ovf_o = 0.
- R9: At 4 bits, subtracting the most negative value, 0 - (-8), gives 4'b1000 with ovf_o = 1 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend when subtracting) |
| b_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| sum_o | output | WIDTH | Truncated result |
| carry_o | output | 1 | Carry out of the most significant bit |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The hardest case to reach is subtracting the most negative value. Inverting that operand yields the largest positive pattern, and only the injected carry-in pushes the result over the sign boundary. A test that only varies operand signs can miss it.

The stimulus walks every operand pair at 4 bits in both modes. Each vector is compared against a signed reference computed with integer arithmetic in the bench.

Named directed vectors come first and pin the specific boundary patterns: positive overflow, negative overflow, mixed-sign non-overflow with a carry, and subtraction of -8.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DEFAULT_WIDTH = 4;
endpackage

// File: rtl/full_adder_cell.sv
module full_adder_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/operand_conditioner.sv
module operand_conditioner #(
  parameter int unsigned WIDTH = addsub_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             cin_o
);
  // subtract: flip every bit and inject +1 through carry-in
  assign b_eff_o = b_i ^ {WIDTH{sub_i}};
  assign cin_o   = sub_i;
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned WIDTH = addsub_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             msb_cin_o,
  output logic             msb_cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    full_adder_cell u_fa (
      .a_i (a_i[g]),
      .b_i (b_i[g]),
      .c_i (carry[g]),
      .s_o (sum_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign msb_cin_o  = carry[MSB];
  assign msb_cout_o = carry[WIDTH];
endmodule

// File: rtl/overflow_detect.sv
module overflow_detect (
  input  logic msb_cin_i,
  input  logic msb_cout_i,
  output logic ovf_o
);
  assign ovf_o = msb_cin_i ^ msb_cout_i;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int unsigned WIDTH = addsub_pkg::DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic             msb_cin;
  logic             msb_cout;

  operand_conditioner #(.WIDTH(WIDTH)) u_cond (
    .b_i     (b_i),
    .sub_i   (sub_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i        (a_i),
    .b_i        (b_eff),
    .cin_i      (cin),
    .sum_o      (sum_o),
    .msb_cin_o  (msb_cin),
    .msb_cout_o (msb_cout)
  );

  overflow_detect u_ovf (
    .msb_cin_i  (msb_cin),
    .msb_cout_i (msb_cout),
    .ovf_o      (ovf_o)
  );

  assign carry_o = msb_cout;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int unsigned WIDTH = addsub_pkg::DEFAULT_WIDTH
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic signed [WIDTH:0] sa, sb, full;
  logic        [WIDTH:0] uwide;

  always_comb begin
    sa    = {a_i[MSB], a_i};
    sb    = {b_i[MSB], b_i};
    full  = sub_i ? (sa - sb) : (sa + sb);
    uwide = sub_i ? ({1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1})
                  : ({1'b0, a_i} + {1'b0, b_i});
  end

  always_comb begin
    if (!sub_i) a_r1_add_result : assert (sum_o == full[MSB:0]);
    if (sub_i)  a_r2_sub_result : assert (sum_o == full[MSB:0]);
    a_r3_carry_out : assert (carry_o == uwide[WIDTH]);
    a_r4_signed_overflow : assert (ovf_o == (full[WIDTH] ^ full[MSB]));
    if (!sub_i && (a_i[MSB] != b_i[MSB])) a_r5_mixed_sign_no_ovf : assert (!ovf_o);
  end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sub_i   (sub_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  localparam int W = 4;
  localparam int SPAN = 1 << W;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic [W-1:0] exp_sum;
    logic         exp_carry;
    logic         exp_ovf;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         carry_o;
  logic         ovf_o;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  addsub_unit #(.WIDTH(W)) dut_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - SPAN : int'(v);
  endfunction

  task automatic drive_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sub, input string tag);
    item_t it;
    int tr;
    tr = sub ? sval(a) - sval(b) : sval(a) + sval(b);
    it.a = a;
    it.b = b;
    it.sub = sub;
    it.exp_sum = W'(tr);
    it.exp_ovf = (tr > SPAN / 2 - 1) || (tr < -SPAN / 2);
    it.exp_carry = sub ? (int'(a) >= int'(b)) : (int'(a) + int'(b) > SPAN - 1);
    it.tag = tag;
    @(posedge clk);
    a_i = a;
    b_i = b;
    sub_i = sub;
    q.push_back(it);
  endtask

  // monitor: pop and compare half a cycle after each drive
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      string rs, rc, ro;
      it = q.pop_front();
      rs = (it.tag != "") ? it.tag : (it.sub ? "R2" : "R1");
      rc = (it.tag != "") ? it.tag : "R3";
      ro = (it.tag != "") ? it.tag : "R4";
      chk(sum_o == it.exp_sum, rs, "sum", int'(sum_o), int'(it.exp_sum));
      chk(carry_o == it.exp_carry, rc, "carry", int'(carry_o), int'(it.exp_carry));
      chk(ovf_o == it.exp_ovf, ro, "ovf", int'(ovf_o), int'(it.exp_ovf));
      if (!it.sub && (it.a[W-1] != it.b[W-1]))
        chk(ovf_o == 1'b0, "R5", "mixed-sign ovf", int'(ovf_o), 0);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // idle inputs after reset: zero result, no flags (R1)
    chk(sum_o == '0 && !carry_o && !ovf_o, "R1", "idle outputs",
        {sum_o, carry_o, ovf_o}, 0);
    rst_ni = 1'b1;

    // directed boundary vectors, tags name the requirement
    drive_vec(4'd7,  4'd3,  1'b0, "R6");   // 7 + 3
    drive_vec(4'hC,  4'd5,  1'b1, "R7");   // -4 - 5
    drive_vec(4'd5,  4'hA,  1'b0, "R8");   // 5 + (-6)
    drive_vec(4'd7,  4'hD,  1'b0, "R8");   // 7 + (-3)
    drive_vec(4'd0,  4'h8,  1'b1, "R9");   // 0 - (-8)

    // exhaustive sweep against the signed reference (R1 R2 R3 R4 R5)
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
          drive_vec(W'(a), W'(b), op[0], "");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule